// File: doc/BRIEF.md
# Sleep and Wake-on-Change Reset Controller

This block manages the low-power sleep state of a small microcontroller core. The instruction decoder raises a one-cycle sleep request. The controller then drops the oscillator-enable output and freezes the I/O output and direction registers. It also clears and restarts its watchdog counter and updates two status bits. The time-out bit reads 1 for "no watchdog expiry" and the power-down bit reads 0 once sleep has been entered.

While asleep, the controller watches several wake sources: an external reset input, the watchdog, a group of monitored input pins and a pair of comparator result bits. The pins and comparator bits are first passed through a synchronizer. Each group is then compared with a snapshot that the core loads whenever it reads that group, so a difference left over from before sleep wakes the device at once. Every wake, and every reset while running, leaves through a wake reset. This reset raises the oscillator enable in the same cycle and then holds the reset output for a fixed number of cycles. Two sticky cause flags record whether a pin change or a comparator change ended the sleep, and they stay readable after that reset.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A `sleep_req` pulse while running, with `ext_rst` low, drives `osc_en` low from the next cycle on, sets `to_bit` to 1 and clears `pd_bit` to 0.
- R2: While asleep and no enabled wake source is present, `osc_en` stays low and `wake_rst` stays low.
- R3: `io_out` and `io_dir` take `io_wdata`/`io_wdir` on `io_we` only while `osc_en` is high; while asleep, writes have no effect.
- R4: `ext_rst` high for one cycle while asleep starts the wake reset on the next cycle, sets no cause flag and leaves `to_bit` unchanged.
- R5: With `pin_wake_en` high, a change of any `pin_in` bit from the value captured by the last `port_rd` wakes the device, with `wake_rst` visible three cycles after the change (two synchronizer stages plus one), and sets `pin_wuf`. With `pin_wake_en` low, the change does not wake the device.
- R6: With `cmp_wake_en` high, a change of either `cmp_in` bit from the value captured by the last `cmp_rd` wakes the device and sets `cmp_wuf` but not `pin_wuf`.
- R7: If a pin mismatch against the snapshot already exists when sleep is entered, `osc_en` is low for exactly one cycle before the wake reset begins. A fresh `port_rd` before sleep removes the mismatch.
- R8: With `wdt_en` high, the device wakes after exactly `WDT_LIMIT` cycles asleep and `to_bit` becomes 0. With `wdt_en` low, the watchdog never wakes it.
- R9: Each wake reset raises `osc_en` and holds `wake_rst` high for `RST_CYC` consecutive cycles, unless `ext_rst` arrives during it and extends it.
- R10: `pd_bit` is 1 after power-on reset, becomes 0 on sleep entry and is never set by a wake.
- R11: `pin_wuf` and `cmp_wuf` survive the wake reset and return to 0 only on `flag_clr` or power-on reset.
- R12: The watchdog counter is cleared on every wake, whatever the source. A watchdog expiry while running also starts a wake reset and clears `to_bit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_req | input | 1 | One-cycle sleep request from the decoder |
| ext_rst | input | 1 | External reset request, active high, synchronous |
| wdt_en | input | 1 | Watchdog enable |
| pin_wake_en | input | 1 | Enables wake on pin change |
| cmp_wake_en | input | 1 | Enables wake on comparator change |
| pin_in | input | NPIN | Monitored input pins (asynchronous) |
| cmp_in | input | NCMP | Comparator result bits (asynchronous) |
| port_rd | input | 1 | Core read of the port; loads the pin snapshot |
| cmp_rd | input | 1 | Core read of the comparator register; loads its snapshot |
| flag_clr | input | 1 | Core write clearing both cause flags |
| io_we | input | 1 | Write strobe for the I/O registers |
| io_wdata | input | IO_W | New output levels |
| io_wdir | input | IO_W | New direction bits (1 = input) |
| osc_en | output | 1 | Oscillator enable, low while asleep |
| wake_rst | output | 1 | Wake/device reset pulse |
| to_bit | output | 1 | Time-out status (0 after watchdog expiry) |
| pd_bit | output | 1 | Power-down status (0 after sleep entry) |
| pin_wuf | output | 1 | Pin-change wake flag |
| cmp_wuf | output | 1 | Comparator-change wake flag |
| pin_val | output | NPIN | Synchronized pin values as read by the core |
| cmp_val | output | NCMP | Synchronized comparator values as read by the core |
| io_out | output | IO_W | Held output register |
| io_dir | output | IO_W | Held direction register |

## Verification
The change detectors are tried with pin changes after a matching read, with comparator changes while the pins match, and with a change left unread before sleep. Together these separate comparison against the snapshot from comparison against the value at sleep entry, and also show which flag each source sets. The same pin change with the enable low shows that wake gating is independent of detection. Watchdog runs measure the exact sleep length. They then measure the running period after an external wake, which shows whether the counter was cleared on that wake rather than merely held.

// File: rtl/swk_pkg.sv
package swk_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_WAKE  = 2'd2
   } swk_state_e;

   typedef struct packed {
      logic ext;
      logic wdt;
      logic pin;
      logic cmp;
   } swk_src_t;
endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], din};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/swk_chg_det.sv
module swk_chg_det #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic         rd,
   output logic [W-1:0] cur,
   output logic         chg
);
   logic [W-1:0] snap;
   logic [W-1:0] diff;

   swk_sync #(.W(W), .STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .q     (cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  snap <= '0;
      else if (rd) snap <= cur;
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign diff[b] = cur[b] ^ snap[b];
   end

   assign chg = |diff;
endmodule

// File: rtl/swk_wdt.sv
module swk_wdt #(
   parameter int LIMIT = 18432
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tmo
);
   localparam int CW = $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign tmo = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr || tmo) cnt <= '0;
      else if (run)        cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
   import swk_pkg::*;
#(
   parameter int RST_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       ext_rst,
   input  logic       wdt_tmo,
   input  logic       wake_req,
   output swk_state_e state,
   output logic       go_sleep,
   output logic       go_wake
);
   localparam int CW = $clog2(RST_CYC);
   localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

   logic [CW-1:0] cnt;

   always_comb begin
      go_sleep = (state == ST_RUN) && sleep_req && !ext_rst;
      go_wake  = 1'b0;
      unique case (state)
         ST_RUN:   go_wake = !go_sleep && (ext_rst || wdt_tmo);
         ST_SLEEP: go_wake = wake_req;
         ST_WAKE:  go_wake = ext_rst;
         default:  go_wake = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RUN;
         cnt   <= '0;
      end else if (go_wake) begin
         state <= ST_WAKE;
         cnt   <= '0;
      end else if (go_sleep) begin
         state <= ST_SLEEP;
      end else if (state == ST_WAKE) begin
         if (cnt == LAST) state <= ST_RUN;
         else             cnt   <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
   import swk_pkg::*;
#(
   parameter int NPIN          = 4,
   parameter int NCMP          = 2,
   parameter int IO_W          = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int WDT_LIMIT     = 18432,
   parameter int RST_CYC       = 4,
   parameter bit IO_RST_INPUT  = 1'b1
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            sleep_req,
   input  logic            ext_rst,
   input  logic            wdt_en,
   input  logic            pin_wake_en,
   input  logic            cmp_wake_en,
   input  logic [NPIN-1:0] pin_in,
   input  logic [NCMP-1:0] cmp_in,
   input  logic            port_rd,
   input  logic            cmp_rd,
   input  logic            flag_clr,
   input  logic            io_we,
   input  logic [IO_W-1:0] io_wdata,
   input  logic [IO_W-1:0] io_wdir,
   output logic            osc_en,
   output logic            wake_rst,
   output logic            to_bit,
   output logic            pd_bit,
   output logic            pin_wuf,
   output logic            cmp_wuf,
   output logic [NPIN-1:0] pin_val,
   output logic [NCMP-1:0] cmp_val,
   output logic [IO_W-1:0] io_out,
   output logic [IO_W-1:0] io_dir
);
   if (NPIN < 1 || NCMP < 1 || IO_W < 1) begin : g_bad_width
      $error("sleep_wake_ctrl: widths must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sleep_wake_ctrl: at least two synchronizer stages required");
   end
   if (WDT_LIMIT < 2 || RST_CYC < 2) begin : g_bad_count
      $error("sleep_wake_ctrl: WDT_LIMIT and RST_CYC must be at least 2");
   end

   localparam logic [IO_W-1:0] DIR_RST = IO_RST_INPUT ? '1 : '0;

   swk_state_e state;
   swk_src_t   src;
   logic       go_sleep, go_wake, from_sleep;
   logic       pin_chg, cmp_chg, wdt_tmo, wdt_run, wake_req;

   swk_chg_det #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pin_det (
      .clk   (clk),
      .rst_n (por_n),
      .din   (pin_in),
      .rd    (port_rd),
      .cur   (pin_val),
      .chg   (pin_chg)
   );

   swk_chg_det #(.W(NCMP), .STAGES(SYNC_STAGES)) u_cmp_det (
      .clk   (clk),
      .rst_n (por_n),
      .din   (cmp_in),
      .rd    (cmp_rd),
      .cur   (cmp_val),
      .chg   (cmp_chg)
   );

   assign wdt_run = wdt_en && (state != ST_WAKE);

   swk_wdt #(.LIMIT(WDT_LIMIT)) u_wdt (
      .clk   (clk),
      .rst_n (por_n),
      .run   (wdt_run),
      .clr   (go_sleep || go_wake),
      .tmo   (wdt_tmo)
   );

   always_comb begin
      src.ext  = ext_rst;
      src.wdt  = wdt_tmo;
      src.pin  = pin_wake_en && pin_chg;
      src.cmp  = cmp_wake_en && cmp_chg;
      wake_req = |src;
   end

   swk_fsm #(.RST_CYC(RST_CYC)) u_fsm (
      .clk       (clk),
      .rst_n     (por_n),
      .sleep_req (sleep_req),
      .ext_rst   (ext_rst),
      .wdt_tmo   (wdt_tmo),
      .wake_req  (wake_req),
      .state     (state),
      .go_sleep  (go_sleep),
      .go_wake   (go_wake)
   );

   assign from_sleep = go_wake && (state == ST_SLEEP);
   assign osc_en     = (state != ST_SLEEP);
   assign wake_rst   = (state == ST_WAKE);

   // status bits
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         to_bit <= 1'b1;
         pd_bit <= 1'b1;
      end else begin
         if (go_wake && src.wdt) to_bit <= 1'b0;
         else if (go_sleep)      to_bit <= 1'b1;
         if (go_sleep)           pd_bit <= 1'b0;
      end
   end

   // cause flags: a new wake event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pin_wuf <= 1'b0;
         cmp_wuf <= 1'b0;
      end else if (from_sleep) begin
         if (src.pin) pin_wuf <= 1'b1;
         if (src.cmp) cmp_wuf <= 1'b1;
      end else if (flag_clr) begin
         pin_wuf <= 1'b0;
         cmp_wuf <= 1'b0;
      end
   end

   // I/O registers frozen while the oscillator is stopped
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         io_out <= '0;
         io_dir <= DIR_RST;
      end else if (io_we && (state != ST_SLEEP)) begin
         io_out <= io_wdata;
         io_dir <= io_wdir;
      end
   end
endmodule

// File: rtl/swk_chk.sv
module swk_chk #(
   parameter int IO_W    = 8,
   parameter int RST_CYC = 4
) (
   input logic            clk,
   input logic            por_n,
   input logic            sleep_req,
   input logic            ext_rst,
   input logic            flag_clr,
   input logic            osc_en,
   input logic            wake_rst,
   input logic            to_bit,
   input logic            pd_bit,
   input logic            pin_wuf,
   input logic            cmp_wuf,
   input logic [IO_W-1:0] io_out,
   input logic [IO_W-1:0] io_dir
);
   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        hi_cnt <= 0;
      else if (wake_rst) hi_cnt <= hi_cnt + 1;
      else               hi_cnt <= 0;
   end

   p_sleep_entry_r1: assert property (@(posedge clk) disable iff (!por_n)
      (sleep_req && osc_en && !wake_rst && !ext_rst) |=> (!osc_en && !pd_bit && to_bit));

   p_io_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
      !osc_en |=> ($stable(io_out) && $stable(io_dir)));

   p_ext_wake_r4: assert property (@(posedge clk) disable iff (!por_n)
      (!osc_en && ext_rst) |=> (osc_en && wake_rst));

   p_rst_len_r9: assert property (@(posedge clk) disable iff (!por_n)
      $fell(wake_rst) |-> (hi_cnt >= RST_CYC));

   p_pd_no_rise_r10: assert property (@(posedge clk) disable iff (!por_n)
      !$rose(pd_bit));

   p_flags_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
      (osc_en && !flag_clr) |=> ($stable(pin_wuf) && $stable(cmp_wuf)));
endmodule

bind sleep_wake_ctrl swk_chk #(.IO_W(IO_W), .RST_CYC(RST_CYC)) u_swk_chk (
   .clk       (clk),
   .por_n     (por_n),
   .sleep_req (sleep_req),
   .ext_rst   (ext_rst),
   .flag_clr  (flag_clr),
   .osc_en    (osc_en),
   .wake_rst  (wake_rst),
   .to_bit    (to_bit),
   .pd_bit    (pd_bit),
   .pin_wuf   (pin_wuf),
   .cmp_wuf   (cmp_wuf),
   .io_out    (io_out),
   .io_dir    (io_dir)
);

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
   localparam int NPIN = 4;
   localparam int NCMP = 2;
   localparam int IO_W = 8;
   localparam int WDT_LIMIT = 64;
   localparam int RST_CYC = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sleep_req = 0, ext_rst = 0, wdt_en = 0, pin_wake_en = 0, cmp_wake_en = 0;
   logic [NPIN-1:0] pin_in = '0;
   logic [NCMP-1:0] cmp_in = '0;
   logic port_rd = 0, cmp_rd = 0, flag_clr = 0, io_we = 0;
   logic [IO_W-1:0] io_wdata = '0, io_wdir = '0;
   logic osc_en, wake_rst, to_bit, pd_bit, pin_wuf, cmp_wuf;
   logic [NPIN-1:0] pin_val;
   logic [NCMP-1:0] cmp_val;
   logic [IO_W-1:0] io_out, io_dir;

   int n_vec = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sleep_wake_ctrl #(
      .NPIN(NPIN), .NCMP(NCMP), .IO_W(IO_W), .SYNC_STAGES(2),
      .WDT_LIMIT(WDT_LIMIT), .RST_CYC(RST_CYC), .IO_RST_INPUT(1'b1)
   ) i_sleep_wake_ctrl (
      .clk(clk), .por_n(por_n), .sleep_req(sleep_req), .ext_rst(ext_rst),
      .wdt_en(wdt_en), .pin_wake_en(pin_wake_en), .cmp_wake_en(cmp_wake_en),
      .pin_in(pin_in), .cmp_in(cmp_in), .port_rd(port_rd), .cmp_rd(cmp_rd),
      .flag_clr(flag_clr), .io_we(io_we), .io_wdata(io_wdata), .io_wdir(io_wdir),
      .osc_en(osc_en), .wake_rst(wake_rst), .to_bit(to_bit), .pd_bit(pd_bit),
      .pin_wuf(pin_wuf), .cmp_wuf(cmp_wuf), .pin_val(pin_val), .cmp_val(cmp_val),
      .io_out(io_out), .io_dir(io_dir)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (3) tick();
   endtask

   task automatic read_all();
      tick(); port_rd = 1; cmp_rd = 1;
      tick(); port_rd = 0; cmp_rd = 0;
   endtask

   task automatic do_sleep();
      tick(); sleep_req = 1;
      tick(); sleep_req = 0;
   endtask

   task automatic wait_wake(input int max, output int n);
      n = 0;
      while (!wake_rst && n < max) begin
         tick();
         n++;
      end
   endtask

   task automatic finish_rst();
      while (wake_rst) tick();
   endtask

   task automatic ext_wake();
      ext_rst = 1; tick(); ext_rst = 0;
      finish_rst();
   endtask

   task automatic clear_flags();
      tick(); flag_clr = 1; tick(); flag_clr = 0;
   endtask

   task automatic t_reset();
      check("R10 pd after por", pd_bit, 1);
      check("R11 pin flag after por", pin_wuf, 0);
      check("R11 cmp flag after por", cmp_wuf, 0);
      check("R9 osc_en after por", osc_en, 1);
      check("R9 wake_rst after por", wake_rst, 0);
      check("R3 io_dir reset", io_dir, 8'hFF);
      check("R8 to after por", to_bit, 1);
   endtask

   task automatic t_sleep_entry();
      int n;
      io_we = 1; io_wdata = 8'h5A; io_wdir = 8'h0F;
      tick(); io_we = 0;
      check("R3 write while running", io_out, 8'h5A);
      do_sleep();
      check("R1 osc_en low", osc_en, 0);
      check("R1 pd cleared", pd_bit, 0);
      check("R1 to set", to_bit, 1);
      io_we = 1; io_wdata = 8'hA5; io_wdir = 8'hF0;
      tick(); io_we = 0;
      check("R3 out held", io_out, 8'h5A);
      check("R3 dir held", io_dir, 8'h0F);
      repeat (10) tick();
      check("R2 still asleep", osc_en, 0);
      check("R2 no reset asleep", wake_rst, 0);
      ext_rst = 1; tick(); ext_rst = 0;
      check("R4 osc_en back", osc_en, 1);
      check("R4 wake_rst on", wake_rst, 1);
      n = 1;
      forever begin
         tick();
         if (wake_rst) n++; else break;
      end
      check("R9 reset length", n, RST_CYC);
      check("R4 no pin flag", pin_wuf, 0);
      check("R4 no cmp flag", cmp_wuf, 0);
      check("R4 to unchanged", to_bit, 1);
      check("R10 pd stays 0", pd_bit, 0);
   endtask

   task automatic t_pin_wake();
      int n;
      pin_wake_en = 1;
      pin_in = 4'b0101; settle(); read_all();
      do_sleep();
      repeat (8) tick();
      check("R5 no wake while matching", osc_en, 0);
      pin_in = 4'b0001;
      wait_wake(20, n);
      check("R5 wake latency", n, 3);
      check("R5 pin flag", pin_wuf, 1);
      check("R6 cmp flag clear", cmp_wuf, 0);
      finish_rst();
      check("R11 pin flag kept", pin_wuf, 1);
      clear_flags();
      check("R11 flag cleared", pin_wuf, 0);
   endtask

   task automatic t_pin_gated();
      pin_wake_en = 0;
      settle(); read_all();
      do_sleep();
      pin_in = 4'b1110;
      repeat (10) tick();
      check("R5 gated no wake", osc_en, 0);
      check("R5 gated no reset", wake_rst, 0);
      ext_wake();
      check("R5 gated no flag", pin_wuf, 0);
   endtask

   task automatic t_cmp_wake();
      int n;
      pin_wake_en = 1; cmp_wake_en = 1;
      cmp_in = 2'b01; settle(); read_all();
      do_sleep();
      repeat (5) tick();
      check("R6 no wake while matching", osc_en, 0);
      cmp_in = 2'b11;
      wait_wake(20, n);
      check("R6 cmp wake", wake_rst, 1);
      check("R6 cmp flag", cmp_wuf, 1);
      check("R6 pin flag clear", pin_wuf, 0);
      finish_rst();
      clear_flags();
      check("R11 cmp flag cleared", cmp_wuf, 0);
      cmp_wake_en = 0;
   endtask

   task automatic t_stale();
      int n;
      pin_wake_en = 1;
      settle(); read_all();
      pin_in = pin_in ^ 4'b0001; settle();
      do_sleep();
      wait_wake(20, n);
      check("R7 immediate wake", n, 1);
      check("R7 pin flag", pin_wuf, 1);
      finish_rst();
      clear_flags();
      read_all();
      do_sleep();
      repeat (6) tick();
      check("R7 reread stays asleep", osc_en, 0);
      ext_wake();
      pin_wake_en = 0;
   endtask

   task automatic t_wdt();
      int n;
      tick(); wdt_en = 1; sleep_req = 1;
      tick(); sleep_req = 0;
      wait_wake(WDT_LIMIT + 20, n);
      check("R8 sleep length", n, WDT_LIMIT);
      check("R8 to cleared", to_bit, 0);
      check("R8 no flags", {pin_wuf, cmp_wuf}, 0);
      finish_rst();
      do_sleep();
      check("R1 to set again", to_bit, 1);
      repeat (20) tick();
      ext_rst = 1; tick(); ext_rst = 0;
      check("R12 to kept after ext wake", to_bit, 1);
      finish_rst();
      wait_wake(WDT_LIMIT + 20, n);
      check("R12 run period after wake", n, WDT_LIMIT);
      check("R12 running timeout clears to", to_bit, 0);
      wdt_en = 0;
      finish_rst();
   endtask

   task automatic t_wdt_gated();
      do_sleep();
      repeat (100) tick();
      check("R8 disabled no wake", osc_en, 0);
      ext_wake();
   endtask

   task automatic t_por();
      int n;
      pin_wake_en = 1;
      settle(); read_all();
      pin_in = pin_in ^ 4'b1000; settle();
      do_sleep();
      wait_wake(20, n);
      finish_rst();
      check("R11 flag before por", pin_wuf, 1);
      por_n = 0; tick(); por_n = 1; tick();
      check("R11 por clears flag", pin_wuf, 0);
      check("R10 por sets pd", pd_bit, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      por_n = 1;
      tick();
      t_reset();
      t_sleep_entry();
      t_pin_wake();
      t_pin_gated();
      t_cmp_wake();
      t_stale();
      t_wdt();
      t_wdt_gated();
      t_por();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule